// File: doc/BRIEF.md
# Stall-Aware Exception Commit Stage

This block moves an exception request from the execute stage of a stalling CPU pipeline into the memory stage and saves processor state at the moment the exception is committed. The request advances only when the pipeline really moves forward. A cycle counter is never used, because branches and cache refills can hold either stage for any number of clocks. A request that cannot advance yet is latched internally, so a brief pulse from an interrupt or a translation-miss source is not lost.

When the exception enters the memory stage, the block records the faulting instruction's program counter as the exception address. It also copies the live translation-enable bit into a saved copy and clears the live bit. An exception return restores the live bit from the saved copy. A memory-stage flush hides the memory-stage flag in the same cycle and blocks any commit in that cycle. The memory-stage flag is also sent back to requesters, so that a source can keep its request high until the exception is taken.

Top module: `excCapture`

## Requirements
- R1: The exception moves into the memory stage at a clock edge only when a request is present (live or latched), `validX` is 1, `stallX` is 0, `stallM` is 0 and `flushM` is 0. `excM` is 1 in the cycle after that edge.
- R2: A request seen while `excAck` is 0 is latched as pending if it cannot advance. It stays pending, even after `excReqX` drops, until it advances. A request seen while `excAck` is 1 is taken as the one already committed and is ignored.
- R3: `excAck` always equals `excM`.
- R4: While `stallM` is 1 and there is no flush, the memory-stage flag holds its value across the edge. When `stallM` is 0 and nothing advances, it clears.
- R5: At the commit edge, `tlbEnSaved` takes the value of `tlbEnLive` and `tlbEnLive` becomes 0. Commit has priority over an exception return and over a live-bit write.
- R6: `excAddr` takes `pcX` only at a commit edge and holds its value at every other edge.
- R7: When `eretM` is 1, `stallM` is 0, `flushM` is 0 and no commit occurs, `tlbEnLive` takes `tlbEnSaved` at the edge. This has priority over a live-bit write.
- R8: While `flushM` is 1, `excM` is 0 in that same cycle, and no commit occurs at that edge.
- R9: After reset, `excM`, the pending request, `excAddr`, `tlbEnLive` and `tlbEnSaved` are all 0.
- R10: When `tlbEnWr` is 1 and neither a commit nor a return occurs, `tlbEnLive` takes `tlbEnWrVal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low synchronous reset |
| excReqX | input | 1 | exception request from execute |
| stallX | input | 1 | execute stage stalled |
| stallM | input | 1 | memory stage stalled |
| validX | input | 1 | execute instruction valid |
| flushM | input | 1 | memory-stage flush |
| eretM | input | 1 | exception return in memory stage |
| tlbEnWr | input | 1 | live translation-enable write strobe |
| tlbEnWrVal | input | 1 | value for that write |
| pcX | input | PC_W | program counter of the execute instruction |
| excM | output | 1 | memory-stage exception flag |
| excAck | output | 1 | feedback to requesters |
| excAddr | output | PC_W | saved exception address |
| tlbEnLive | output | 1 | live translation-enable bit |
| tlbEnSaved | output | 1 | saved translation-enable bit |

## Verification
The bench builds the block with `PC_W` = 6, so the program counter is small enough to drive with a value that changes every cycle. A captured address can then be traced to the exact edge that took it. Every combination of the seven control inputs is applied from several starting states. This brings each priority collision within reach: flush against advance, commit against return, and return against write. A long pseudo-random run follows, with stalls weighted heavily so that requests pile up as pending.

// File: rtl/excPkg.sv
package excPkg;
  typedef struct packed {
    logic commit;   // exception enters memory stage this edge
    logic eret;     // effective exception return
    logic swWrite;  // live-bit write request
  } excStrobes_t;
endpackage

// File: rtl/excCtrl.sv
module excCtrl
  import excPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        excReqX,
  input  logic        stallX,
  input  logic        stallM,
  input  logic        validX,
  input  logic        flushM,
  input  logic        eretM,
  input  logic        tlbEnWr,
  output logic        excM,
  output excStrobes_t strb
);
  logic pendReg;
  logic excMReg;
  logic newReq;
  logic excX;
  logic advance;

  assign excM    = excMReg & ~flushM;
  assign newReq  = excReqX & ~excM;
  assign excX    = pendReg | newReq;
  assign advance = excX & validX & ~stallX & ~stallM & ~flushM;

  always_comb begin
    strb         = '0;
    strb.commit  = advance;
    strb.eret    = eretM & ~stallM & ~flushM;
    strb.swWrite = tlbEnWr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendReg <= 1'b0;
      excMReg <= 1'b0;
    end else begin
      pendReg <= advance ? 1'b0 : excX;
      if (flushM)       excMReg <= 1'b0;
      else if (advance) excMReg <= 1'b1;
      else if (!stallM) excMReg <= 1'b0;
    end
  end

  // R1: a rise of the flag needs real progress of both stages
  a_r1_rise_needs_progress: assert property (@(posedge clk) disable iff (!rstN)
    $rose(excMReg) |-> $past(validX && !stallX && !stallM && !flushM));
  // R2: pending request survives until it advances
  a_r2_pending_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (pendReg && !(validX && !stallX && !stallM && !flushM)) |=> pendReg);
  // R4: memory stall without flush freezes the flag
  a_r4_stall_holds: assert property (@(posedge clk) disable iff (!rstN)
    (stallM && !flushM) |=> excMReg == $past(excMReg));
  // R8: a flush leaves nothing committed
  a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rstN)
    flushM |=> !excMReg);
endmodule

// File: rtl/excData.sv
module excData
  import excPkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  excStrobes_t     strb,
  input  logic [PC_W-1:0] pcX,
  input  logic            tlbEnWrVal,
  output logic [PC_W-1:0] excAddr,
  output logic            tlbEnLive,
  output logic            tlbEnSaved
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      excAddr    <= '0;
      tlbEnLive  <= 1'b0;
      tlbEnSaved <= 1'b0;
    end else if (strb.commit) begin
      excAddr    <= pcX;
      tlbEnSaved <= tlbEnLive;
      tlbEnLive  <= 1'b0;
    end else if (strb.eret) begin
      tlbEnLive  <= tlbEnSaved;
    end else if (strb.swWrite) begin
      tlbEnLive  <= tlbEnWrVal;
    end
  end

  // R5: commit saves then clears the live bit
  a_r5_save_clear: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> (!tlbEnLive && tlbEnSaved == $past(tlbEnLive)));
  // R6: address changes only on commit
  a_r6_addr_only_commit: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(excAddr));
  // R7: return restores live bit
  a_r7_eret_restore: assert property (@(posedge clk) disable iff (!rstN)
    (strb.eret && !strb.commit) |=> tlbEnLive == $past(tlbEnSaved));
endmodule

// File: rtl/excCapture.sv
module excCapture
  import excPkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            excReqX,
  input  logic            stallX,
  input  logic            stallM,
  input  logic            validX,
  input  logic            flushM,
  input  logic            eretM,
  input  logic            tlbEnWr,
  input  logic            tlbEnWrVal,
  input  logic [PC_W-1:0] pcX,
  output logic            excM,
  output logic            excAck,
  output logic [PC_W-1:0] excAddr,
  output logic            tlbEnLive,
  output logic            tlbEnSaved
);
  excStrobes_t strb;

  excCtrl uCtrl (
    .clk(clk), .rstN(rstN), .excReqX(excReqX), .stallX(stallX),
    .stallM(stallM), .validX(validX), .flushM(flushM), .eretM(eretM),
    .tlbEnWr(tlbEnWr), .excM(excM), .strb(strb)
  );

  excData #(.PC_W(PC_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .pcX(pcX),
    .tlbEnWrVal(tlbEnWrVal), .excAddr(excAddr),
    .tlbEnLive(tlbEnLive), .tlbEnSaved(tlbEnSaved)
  );

  assign excAck = excM;

  // R3: feedback mirrors the memory-stage flag
  always_comb a_r3_ack_match: assert (excAck == excM);
endmodule

// File: tb/tb_excCapture.sv
module tb_excCapture;
  localparam int PC_W = 6;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic excReqX = 0, stallX = 0, stallM = 0, validX = 0, flushM = 0;
  logic eretM = 0, tlbEnWr = 0, tlbEnWrVal = 0;
  logic [PC_W-1:0] pcX = '0;
  logic excM, excAck, tlbEnLive, tlbEnSaved;
  logic [PC_W-1:0] excAddr;
  int total = 0, bad = 0;
  bit done = 0;
  // model state
  bit mPend = 0, mExc = 0, mLive = 0, mSaved = 0;
  logic [PC_W-1:0] mAddr = '0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  excCapture #(.PC_W(PC_W)) dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // drive one cycle after negedge, check, advance model at posedge
  task automatic step(input logic [6:0] c, input logic [PC_W-1:0] pc);
    bit ack, excX, adv, er;
    {excReqX, stallX, stallM, validX, flushM, eretM, tlbEnWr} = c;
    tlbEnWrVal = pc[0];
    pcX = pc;
    #1;
    ack = mExc & ~flushM;
    if (flushM) chk("R8", excM, 0);
    else chk("R1", excM, ack);
    chk("R3", excAck, excM);
    chk("R6", excAddr, mAddr);
    chk("R5", tlbEnSaved, mSaved);
    chk(eretM ? "R7" : "R10", tlbEnLive, mLive);
    excX = mPend | (excReqX & ~ack);
    adv = excX & validX & ~stallX & ~stallM & ~flushM;
    er = eretM & ~stallM & ~flushM;
    mPend = adv ? 0 : excX;
    if (flushM) mExc = 0; else if (adv) mExc = 1; else if (!stallM) mExc = 0;
    if (adv) begin mAddr = pc; mSaved = mLive; mLive = 0; end
    else if (er) mLive = mSaved;
    else if (tlbEnWr) mLive = tlbEnWrVal;
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", excM, 0); chk("R9", excAddr, 0);
    chk("R9", tlbEnLive, 0); chk("R9", tlbEnSaved, 0);
    rstN = 1;
    // R10 set live bit, R2 one-cycle pulse during stall, then commit
    step(7'b0000001, 6'd1);            // write live=1
    step(7'b1010000, 6'd9);            // pulse while M stalled
    step(7'b0010000, 6'd10);           // still stalled, pulse gone
    step(7'b0001000, 6'd12);           // advances, R2 pending used
    chk("R2", excM, 1); chk("R6", excAddr, 12);
    chk("R5", tlbEnLive, 0); chk("R5", tlbEnSaved, 1);
    step(7'b0001000, 6'd13);           // flag leaves
    step(7'b0000010, 6'd14);           // eret restores
    chk("R7", tlbEnLive, 1);
    // exhaustive sweep of controls, repeated from varied states
    for (int p = 0; p < 6; p++)
      for (int i = 0; i < 128; i++) step(i[6:0] ^ {p[2:0], 4'b0}, 6'(i * 5 + p));
    // pseudo-random run
    for (int n = 0; n < 4000; n++) begin
      logic [6:0] c;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      c[6] = lfsr[0] & lfsr[3];
      c[5] = lfsr[1] & lfsr[4];
      c[4] = lfsr[2] | lfsr[7];
      c[3] = lfsr[5] | lfsr[6];
      c[2] = lfsr[8] & lfsr[9] & lfsr[10];
      c[1] = lfsr[11] & lfsr[12];
      c[0] = lfsr[13] & lfsr[14];
      step(c, lfsr[PC_W+1:2]);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule